// File: doc/BRIEF.md
# Seven-Input Interrupt Level Encoder

The block sits between a set of interrupt sources and a processor that takes its interrupt request as a small binary priority level. It has seven active-high request lines, numbered 1 to 7. From them it forms a registered level code that equals the number of the highest line currently requesting. When no line requests, the code is zero.

Lines 1 to 6 are level-sensitive. Each stays requested for as long as its source holds it high, and only the source can withdraw it. Line 7 is the non-maskable line, which is normally driven by a push switch. Only a rising edge on line 7 counts as a request. The block latches that edge until the processor acknowledges level 7.

The block compares the level against the processor's 3-bit interrupt mask and drives a pending flag from the result. A mask of zero lets every level through. Level 7 is pending whatever the mask holds.

On a one-cycle acknowledge strobe, the block returns an autovector number on the next cycle. The number is the base 24 plus the level being served. When nothing is pending, the block returns the spurious-interrupt vector 24 instead.

Top module: `irq_level_encoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `level_o`, `pending_o`, `vector_o` and `vector_valid_o` are all zero.
- R2: The register `level_o` is updated on every clock edge to the number of the highest requesting line. Bit k of `req_i` is line k+1. Lines 1 to 6 count while they are high, and line 7 counts while its latched request is set. When nothing requests, `level_o` is 0.
- R3: For a level of 1 to 6, `pending_o` is 1 only when the level is strictly greater than the `mask_i` value it was registered with. Level 0 is never pending.
- R4: Level 7 is pending for every value of `mask_i`, including 7.
- R5: A 0-to-1 transition of line 7 (`req_i[6]`) sets the non-maskable request. The request then stays set after line 7 falls again. Holding line 7 high does not request again once the request has been acknowledged, and only a new rising edge does.
- R6: When `ack_i` is high in a cycle with a pending level n, `vector_o` is 24+n on the next cycle. In that cycle `vector_valid_o` is 1, and otherwise `vector_valid_o` is 0.
- R7: When `ack_i` is high in a cycle with nothing pending, `vector_o` is the spurious vector 24 on the next cycle. This covers a requesting level that the mask blocks.
- R8: An acknowledge served at level 7 clears the non-maskable request, so the next level shown is the highest of lines 1 to 6. An acknowledge at a lower level leaves that line's request in place.
- R9: A rising edge on line 7 in the same cycle as `ack_i` is served at once. It returns vector 31 and leaves no non-maskable request set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Request lines; bit k is line k+1, bit 6 is the non-maskable line |
| mask_i | input | 3 | Processor interrupt mask |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| level_o | output | 3 | Registered highest requesting level |
| pending_o | output | 1 | Registered flag: level passes the mask |
| vector_o | output | 8 | Autovector number returned for the last acknowledge |
| vector_valid_o | output | 1 | High for the one cycle that follows an acknowledge |

## Verification
The bench builds the block with its default parameters. These are seven request lines, a vector base of 24 and an 8-bit vector, which make the non-maskable top level and every mask value from 0 to 7 reachable. The bench runs each line alone and in combination, and it sets the mask equal to and just below the level. It also covers an acknowledge with nothing pending and one with a masked request. For line 7 it covers a held high level, a release before the acknowledge, and a rising edge that coincides with the acknowledge. Each of these outcomes can be seen at the ports with these values.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  // width needed to hold a level number 0..n
  function automatic int level_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
// Edge-captured request for the top (non-maskable) line.
module irq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic clear_i,
  output logic active_o
);
  logic line_q;
  logic held_q;
  logic rise;

  assign rise     = line_i & ~line_q;
  assign active_o = held_q | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      line_q <= line_i;
      held_q <= active_o & ~clear_i;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
// Highest-set-line encoder; line numbers start at 1.
module irq_prio_enc #(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] stage [N+1];

  assign stage[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_stage
    assign stage[i+1] = req_i[i] ? W'(i + 1) : stage[i];
  end
  assign code_o = stage[N];
endmodule

// File: rtl/irq_gate.sv
// Mask comparison, autovector selection and output registers.
module irq_gate #(
  parameter int W     = 3,
  parameter int TOP   = 7,
  parameter int VBASE = 24,
  parameter int VW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  code_i,
  input  logic [W-1:0]  mask_i,
  input  logic          ack_i,
  output logic          pend_now_o,
  output logic [W-1:0]  level_o,
  output logic          pending_o,
  output logic [VW-1:0] vector_o,
  output logic          vector_valid_o
);
  localparam logic [W-1:0]  TOP_CODE = W'(TOP);
  localparam logic [VW-1:0] SPURIOUS = VW'(VBASE);

  assign pend_now_o = (code_i == TOP_CODE) || (code_i > mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o        <= '0;
      pending_o      <= 1'b0;
      vector_o       <= '0;
      vector_valid_o <= 1'b0;
    end else begin
      level_o        <= code_i;
      pending_o      <= pend_now_o;
      vector_valid_o <= ack_i;
      if (ack_i) begin
        vector_o <= pend_now_o ? SPURIOUS + VW'(code_i) : SPURIOUS;
      end
    end
  end
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
  parameter int NUM_LEVELS = 7,
  parameter int VEC_BASE   = 24,
  parameter int VEC_W      = 8,
  localparam int LVL_W     = irq_enc_pkg::level_width(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic [LVL_W-1:0]      mask_i,
  input  logic                  ack_i,
  output logic [LVL_W-1:0]      level_o,
  output logic                  pending_o,
  output logic [VEC_W-1:0]      vector_o,
  output logic                  vector_valid_o
);
  logic                  nmi_active;
  logic                  nmi_clear;
  logic                  pend_now;
  logic [NUM_LEVELS-1:0] eff_req;
  logic [LVL_W-1:0]      code;

  irq_edge_latch u_nmi (
    .clk      (clk),
    .rst      (rst),
    .line_i   (req_i[NUM_LEVELS-1]),
    .clear_i  (nmi_clear),
    .active_o (nmi_active)
  );

  assign eff_req = {nmi_active, req_i[NUM_LEVELS-2:0]};

  irq_prio_enc #(.N(NUM_LEVELS), .W(LVL_W)) u_enc (
    .req_i  (eff_req),
    .code_o (code)
  );

  assign nmi_clear = ack_i && (code == LVL_W'(NUM_LEVELS));

  irq_gate #(.W(LVL_W), .TOP(NUM_LEVELS), .VBASE(VEC_BASE), .VW(VEC_W)) u_gate (
    .clk            (clk),
    .rst            (rst),
    .code_i         (code),
    .mask_i         (mask_i),
    .ack_i          (ack_i),
    .pend_now_o     (pend_now),
    .level_o        (level_o),
    .pending_o      (pending_o),
    .vector_o       (vector_o),
    .vector_valid_o (vector_valid_o)
  );
endmodule

// File: rtl/irq_level_encoder_chk.sv
module irq_level_encoder_chk #(
  parameter int NUM_LEVELS = 7,
  parameter int VEC_BASE   = 24,
  parameter int VEC_W      = 8,
  parameter int LVL_W      = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [LVL_W-1:0]      mask_i,
  input logic                  ack_i,
  input logic [LVL_W-1:0]      level_o,
  input logic                  pending_o,
  input logic [VEC_W-1:0]      vector_o,
  input logic                  vector_valid_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (level_o == '0 && !pending_o && !vector_valid_o && vector_o == '0));

  assert_mask_strict_R3: assert property (@(posedge clk) disable iff (rst)
    (pending_o && level_o != LVL_W'(NUM_LEVELS)) |-> (level_o > $past(mask_i)));

  assert_zero_not_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (level_o == '0) |-> !pending_o);

  assert_top_unmaskable_R4: assert property (@(posedge clk) disable iff (rst)
    (level_o == LVL_W'(NUM_LEVELS)) |-> pending_o);

  assert_valid_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> vector_valid_o);

  assert_valid_only_ack_R6: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !vector_valid_o);

  assert_vector_range_R7: assert property (@(posedge clk) disable iff (rst)
    vector_valid_o |-> (vector_o >= VEC_W'(VEC_BASE) &&
                        vector_o <= VEC_W'(VEC_BASE + NUM_LEVELS)));
endmodule

bind irq_level_encoder irq_level_encoder_chk #(
  .NUM_LEVELS(NUM_LEVELS), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W), .LVL_W(LVL_W)
) i_chk (
  .clk            (clk),
  .rst            (rst),
  .mask_i         (mask_i),
  .ack_i          (ack_i),
  .level_o        (level_o),
  .pending_o      (pending_o),
  .vector_o       (vector_o),
  .vector_valid_o (vector_valid_o)
);

// File: tb/test_irq_level_encoder.sv
`timescale 1ns/1ps
module test_irq_level_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req = '0;
  logic [2:0] mask = '0;
  logic       ack = 1'b0;
  logic [2:0] level_o;
  logic       pending_o;
  logic [7:0] vector_o;
  logic       vector_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_prev7 = 0, m_nmi = 0;
  int e_level = 0, e_pend = 0, e_vec = 0, e_valid = 0;

  always #4 clk = ~clk;

  irq_level_encoder i_irq_level_encoder (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .ack_i(ack),
    .level_o(level_o), .pending_o(pending_o), .vector_o(vector_o),
    .vector_valid_o(vector_valid_o)
  );

  always @(posedge clk) begin
    int lvl, pend, now7;
    if (rst) begin
      m_prev7 = 0; m_nmi = 0;
      e_level = 0; e_pend = 0; e_vec = 0; e_valid = 0;
    end else begin
      now7 = m_nmi || (req[6] && !m_prev7);
      lvl = 0;
      for (int i = 1; i <= 6; i++) if (req[i-1]) lvl = i;
      if (now7) lvl = 7;
      pend = (lvl == 7) || (lvl != 0 && lvl > mask);
      e_level = lvl;
      e_pend  = pend;
      e_valid = ack;
      if (ack) e_vec = pend ? 24 + lvl : 24;
      m_nmi   = (now7 && !(ack && lvl == 7)) ? 1 : 0;
      m_prev7 = req[6];
    end
  end

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check1(tag, "level", int'(level_o), e_level);
    check1(tag, "pending", int'(pending_o), e_pend);
    check1(tag, "valid", int'(vector_valid_o), e_valid);
    check1(tag, "vector", int'(vector_o), e_vec);
  endtask

  task automatic step(input logic [6:0] r, input logic [2:0] m, input logic a, input string tag);
    req = r; mask = m; ack = a;
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0;
    compare(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    check1("R1", "level_zero", int'(level_o), 0);
    rst = 1'b0;
    step(7'b0000000, 3'd0, 1'b0, "R2");
    // each of lines 1..6 alone, mask 0
    for (int i = 0; i < 6; i++) step(7'(1 << i), 3'd0, 1'b0, "R2");
    step(7'b0000011, 3'd0, 1'b0, "R2");
    step(7'b0101001, 3'd0, 1'b0, "R2");
    // strict mask comparison
    step(7'b0000100, 3'd3, 1'b0, "R3");
    step(7'b0000100, 3'd2, 1'b0, "R3");
    step(7'b0100000, 3'd6, 1'b0, "R3");
    step(7'b0100000, 3'd5, 1'b0, "R3");
    // acknowledge with a pending level
    step(7'b0000010, 3'd0, 1'b1, "R6");
    step(7'b0000010, 3'd0, 1'b0, "R8");   // lower line still requesting
    step(7'b0100000, 3'd1, 1'b1, "R6");
    // spurious acknowledges
    step(7'b0000000, 3'd0, 1'b1, "R7");
    step(7'b0000001, 3'd1, 1'b1, "R7");
    // non-maskable line
    step(7'b1000010, 3'd7, 1'b0, "R4");
    step(7'b1000010, 3'd7, 1'b0, "R5");
    step(7'b0000010, 3'd7, 1'b0, "R5");   // released before ack, still latched
    step(7'b0000010, 3'd7, 1'b1, "R8");   // served -> 31
    step(7'b0000010, 3'd0, 1'b0, "R8");   // back to line 2
    step(7'b1000010, 3'd0, 1'b0, "R5");
    step(7'b1000010, 3'd0, 1'b1, "R8");
    step(7'b1000010, 3'd0, 1'b0, "R5");   // held high, no new request
    step(7'b1000010, 3'd0, 1'b0, "R5");
    step(7'b0000000, 3'd0, 1'b0, "R5");
    // rising edge coincident with acknowledge
    step(7'b1000000, 3'd4, 1'b1, "R9");
    step(7'b1000000, 3'd4, 1'b0, "R9");
    step(7'b0000000, 3'd4, 1'b0, "R9");
    // reset clears a latched request
    step(7'b1000000, 3'd0, 1'b0, "R4");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(7'b1000000, 3'd0, 1'b0, "R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule